// File: doc/BRIEF.md
# Multi-Cycle Effective Address Unit

This unit turns an addressing-mode code, up to two operand bytes and a snapshot of the X, Y, stack-pointer and next-PC values into a 16-bit effective address for an 8-bit processor core. It handles the direct forms in one computation cycle: zero page, zero-page indexed, absolute, absolute indexed, relative branch target and stack slot. For the three pointer forms it first reads a two-byte pointer through a single-port synchronous memory read port, and then finishes the address.

A request is taken only while the unit is idle. The unit captures every request input on the accepting clock edge, so the caller may change them right after. When the address is ready the unit raises a one-cycle done strobe together with the address. In the same cycle it raises a flag if the access needed an additional cycle because an index addition on a read crossed a 256-byte page.

Top module: `addr_gen_unit`

## Requirements
- R1: While reset is asserted and after its release with no request, busy, done, mem_rd and extra_cycle are all low.
- R2: Mode codes 0 (zero page), 1 (zero page plus X) and 2 (zero page plus Y) give an address whose high byte is 0. The low byte is the operand low byte, or that byte plus the index taken modulo 256.
- R3: Mode 3 gives {opnd_hi, opnd_lo}. Codes 11 to 15 behave exactly like mode 3.
- R4: Modes 4 (absolute plus X) and 5 (absolute plus Y) add the zero-extended index to {opnd_hi, opnd_lo} as a 16-bit sum. When the sum's high byte differs from opnd_hi on a read (req_write low), done comes one cycle later and extra_cycle is high with it. Writes never take the extra cycle.
- R5: Mode 6 (jump indirect) reads the low pointer byte at {opnd_hi, opnd_lo} and then the high pointer byte at {opnd_hi, opnd_lo+1 mod 256}. It never carries into the next page. The result is {high, low}.
- R6: Mode 7 (pre-indexed indirect) forms p = opnd_lo + X mod 256. It reads the low byte at {0x00, p} and the high byte at {0x00, p+1 mod 256}, and the result is the pointer itself.
- R7: Mode 8 (post-indexed indirect) reads the low byte at {0x00, opnd_lo} and the high byte at {0x00, opnd_lo+1 mod 256}. It then adds the zero-extended Y as a 16-bit sum. A page cross on a read adds one cycle and raises extra_cycle, as in R4.
- R8: Mode 9 gives pc_next plus opnd_lo read as a signed two's-complement byte, modulo 65536.
- R9: Mode 10 gives {0x01, reg_s}.
- R10: Pointer reads are two consecutive mem_rd cycles, low byte first. The memory returns each byte on mem_rdata in the cycle after the read and holds it until the next read.
- R11: Take the accepting rising edge as edge 1. done is high for exactly one cycle: the cycle after edge 2 for direct modes, or after edge 4 for the pointer modes, plus one for a page-cross read. busy is low in the done cycle.
- R12: req_valid is ignored while busy is high. The address and timing of the request in flight are unchanged, and no second done follows.
- R13: extra_cycle is high only in the done cycle of a page-crossing read in modes 4, 5 or 8, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_mode | input | 4 | Addressing-mode code |
| req_write | input | 1 | Access is a write (no page-cross penalty) |
| opnd_lo | input | 8 | First operand byte (low address or offset) |
| opnd_hi | input | 8 | Second operand byte (high address) |
| reg_x | input | 8 | X index value |
| reg_y | input | 8 | Y index value |
| reg_s | input | 8 | Stack pointer value |
| pc_next | input | 16 | Address of the byte after the operand |
| busy | output | 1 | Request in progress |
| mem_rd | output | 1 | Pointer byte read strobe |
| mem_addr | output | 16 | Pointer byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| done | output | 1 | One-cycle strobe: ea is valid |
| ea | output | 16 | Effective address |
| extra_cycle | output | 1 | Page-cross extra cycle was taken |

## Verification
The checker relies on the request fields being meaningful only at the edge where req_valid meets an idle unit. It also relies on mem_rdata presenting the byte for the previous read until the next read. The bench drives every input on the falling edge and samples on the falling edge. Its memory model registers the read byte on the rising edge after mem_rd and holds it otherwise. Pointer contents come from a small override table that each scenario fills, placed on page-wrap and page-cross corners.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  localparam int AW = 16;
  localparam int BW = 8;
  localparam int MW = 4;
  localparam logic [BW-1:0] ZERO_PAGE  = '0;
  localparam logic [BW-1:0] STACK_PAGE = 8'h01;

  typedef enum logic [MW-1:0] {
    AM_ZP    = 4'd0,
    AM_ZPX   = 4'd1,
    AM_ZPY   = 4'd2,
    AM_ABS   = 4'd3,
    AM_ABSX  = 4'd4,
    AM_ABSY  = 4'd5,
    AM_JIND  = 4'd6,
    AM_PREX  = 4'd7,
    AM_POSTY = 4'd8,
    AM_REL   = 4'd9,
    AM_STK   = 4'd10
  } am_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PLO, S_PHI, S_CALC, S_FIX
  } st_e;

  function automatic logic uses_pointer(am_e m);
    return (m == AM_JIND) || (m == AM_PREX) || (m == AM_POSTY);
  endfunction

  function automatic logic may_cross(am_e m);
    return (m == AM_ABSX) || (m == AM_ABSY) || (m == AM_POSTY);
  endfunction
endpackage

// File: rtl/agu_addr_calc.sv
`timescale 1ns/1ps
module agu_addr_calc
  import agu_pkg::*;
(
  input  am_e           mode,
  input  logic [BW-1:0] opl,
  input  logic [BW-1:0] oph,
  input  logic [BW-1:0] ix,
  input  logic [BW-1:0] iy,
  input  logic [BW-1:0] sp,
  input  logic [AW-1:0] pc_nxt,
  input  logic [BW-1:0] pl,
  input  logic [BW-1:0] ph,
  output logic [AW-1:0] ptr0,
  output logic [AW-1:0] ptr1,
  output logic [AW-1:0] eff,
  output logic          crossed
);
  localparam int XW = AW - BW;

  logic [BW-1:0] zp_x, zp_y, opl_inc, zp_x_inc;
  logic [AW-1:0] abs_base, ptr_val, sum_x, sum_y, sum_post, rel_sum;

  assign zp_x     = opl + ix;
  assign zp_y     = opl + iy;
  assign opl_inc  = opl + 1'b1;
  assign zp_x_inc = zp_x + 1'b1;
  assign abs_base = {oph, opl};
  assign ptr_val  = {ph, pl};
  assign sum_x    = abs_base + {{XW{1'b0}}, ix};
  assign sum_y    = abs_base + {{XW{1'b0}}, iy};
  assign sum_post = ptr_val + {{XW{1'b0}}, iy};
  assign rel_sum  = pc_nxt + {{XW{opl[BW-1]}}, opl};

  always_comb begin
    ptr0    = abs_base;
    ptr1    = {oph, opl_inc};
    eff     = abs_base;
    crossed = 1'b0;
    case (mode)
      AM_ZP:   eff = {ZERO_PAGE, opl};
      AM_ZPX:  eff = {ZERO_PAGE, zp_x};
      AM_ZPY:  eff = {ZERO_PAGE, zp_y};
      AM_ABSX: begin
        eff     = sum_x;
        crossed = (sum_x[AW-1:BW] != oph);
      end
      AM_ABSY: begin
        eff     = sum_y;
        crossed = (sum_y[AW-1:BW] != oph);
      end
      AM_JIND: eff = ptr_val;
      AM_PREX: begin
        ptr0 = {ZERO_PAGE, zp_x};
        ptr1 = {ZERO_PAGE, zp_x_inc};
        eff  = ptr_val;
      end
      AM_POSTY: begin
        ptr0    = {ZERO_PAGE, opl};
        ptr1    = {ZERO_PAGE, opl_inc};
        eff     = sum_post;
        crossed = (sum_post[AW-1:BW] != ph);
      end
      AM_REL:  eff = rel_sum;
      AM_STK:  eff = {STACK_PAGE, sp};
      default: eff = abs_base;
    endcase
  end
endmodule

// File: rtl/agu_seq.sv
`timescale 1ns/1ps
module agu_seq
  import agu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  am_e           req_mode,
  input  logic          req_write,
  input  logic [BW-1:0] req_opl,
  input  logic [BW-1:0] req_oph,
  input  logic [BW-1:0] req_x,
  input  logic [BW-1:0] req_y,
  input  logic [BW-1:0] req_s,
  input  logic [AW-1:0] req_pc,
  input  logic [BW-1:0] rdata,
  input  logic [AW-1:0] c_ptr0,
  input  logic [AW-1:0] c_ptr1,
  input  logic [AW-1:0] c_eff,
  input  logic          c_crossed,
  output am_e           q_mode,
  output logic [BW-1:0] q_opl,
  output logic [BW-1:0] q_oph,
  output logic [BW-1:0] q_x,
  output logic [BW-1:0] q_y,
  output logic [BW-1:0] q_s,
  output logic [AW-1:0] q_pc,
  output logic [BW-1:0] q_plo,
  output logic          busy,
  output logic          rd,
  output logic [AW-1:0] rd_addr,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          extra
);
  st_e  state_q, state_d;
  logic wr_q;
  logic accept, cap_plo, ea_en, done_d, extra_d;

  assign accept  = req_valid && (state_q == S_IDLE);
  assign busy    = (state_q != S_IDLE);
  assign rd      = (state_q == S_PLO) || (state_q == S_PHI);
  assign rd_addr = (state_q == S_PHI) ? c_ptr1 : c_ptr0;
  assign cap_plo = (state_q == S_PHI);

  always_comb begin
    state_d = state_q;
    ea_en   = 1'b0;
    done_d  = 1'b0;
    extra_d = 1'b0;
    case (state_q)
      S_IDLE: if (accept) state_d = uses_pointer(req_mode) ? S_PLO : S_CALC;
      S_PLO:  state_d = S_PHI;
      S_PHI:  state_d = S_CALC;
      S_CALC: begin
        ea_en = 1'b1;
        if (c_crossed && !wr_q && may_cross(q_mode)) begin
          state_d = S_FIX;
        end else begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      S_FIX: begin
        state_d = S_IDLE;
        done_d  = 1'b1;
        extra_d = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done    <= 1'b0;
      extra   <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      extra   <= extra_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_mode <= AM_ZP;
      wr_q   <= 1'b0;
      q_opl  <= '0;
      q_oph  <= '0;
      q_x    <= '0;
      q_y    <= '0;
      q_s    <= '0;
      q_pc   <= '0;
    end else if (accept) begin
      q_mode <= req_mode;
      wr_q   <= req_write;
      q_opl  <= req_opl;
      q_oph  <= req_oph;
      q_x    <= req_x;
      q_y    <= req_y;
      q_s    <= req_s;
      q_pc   <= req_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_plo <= '0;
    else if (cap_plo) q_plo <= rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ea <= '0;
    else if (ea_en) ea <= c_eff;
  end
endmodule

// File: rtl/addr_gen_unit.sv
`timescale 1ns/1ps
module addr_gen_unit
  import agu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [MW-1:0] req_mode,
  input  logic          req_write,
  input  logic [BW-1:0] opnd_lo,
  input  logic [BW-1:0] opnd_hi,
  input  logic [BW-1:0] reg_x,
  input  logic [BW-1:0] reg_y,
  input  logic [BW-1:0] reg_s,
  input  logic [AW-1:0] pc_next,
  output logic          busy,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [BW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          extra_cycle
);
  am_e           q_mode;
  logic [BW-1:0] q_opl, q_oph, q_x, q_y, q_s, q_plo;
  logic [AW-1:0] q_pc, c_ptr0, c_ptr1, c_eff;
  logic          c_crossed;

  agu_seq seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(am_e'(req_mode)),
    .req_write(req_write), .req_opl(opnd_lo), .req_oph(opnd_hi), .req_x(reg_x),
    .req_y(reg_y), .req_s(reg_s), .req_pc(pc_next), .rdata(mem_rdata),
    .c_ptr0(c_ptr0), .c_ptr1(c_ptr1), .c_eff(c_eff), .c_crossed(c_crossed),
    .q_mode(q_mode), .q_opl(q_opl), .q_oph(q_oph), .q_x(q_x), .q_y(q_y),
    .q_s(q_s), .q_pc(q_pc), .q_plo(q_plo), .busy(busy), .rd(mem_rd),
    .rd_addr(mem_addr), .done(done), .ea(ea), .extra(extra_cycle)
  );

  agu_addr_calc calc_i (
    .mode(q_mode), .opl(q_opl), .oph(q_oph), .ix(q_x), .iy(q_y), .sp(q_s),
    .pc_nxt(q_pc), .pl(q_plo), .ph(mem_rdata), .ptr0(c_ptr0), .ptr1(c_ptr1),
    .eff(c_eff), .crossed(c_crossed)
  );
endmodule

// File: rtl/agu_checker.sv
`timescale 1ns/1ps
module agu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [3:0]  req_mode,
  input logic [7:0]  reg_s,
  input logic        busy,
  input logic        mem_rd,
  input logic        done,
  input logic [15:0] ea,
  input logic        extra_cycle
);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> mem_rd);
  // R10
  rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);
  // R10
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
  // R13
  extra_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    extra_cycle |-> done);
  // R12
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> !busy);
  // R9
  stack_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_valid && !busy && req_mode == 4'd10, 2))
      |-> (ea == {8'h01, $past(reg_s, 2)}));
  // R2
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_valid && !busy && req_mode <= 4'd2, 2))
      |-> (ea[15:8] == 8'h00));
endmodule

bind addr_gen_unit agu_checker chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .reg_s(reg_s), .busy(busy), .mem_rd(mem_rd), .done(done), .ea(ea),
  .extra_cycle(extra_cycle)
);

// File: tb/addr_gen_unit_tb_top.sv
`timescale 1ns/1ps
module addr_gen_unit_tb_top;
  logic        clk, rst_n, req_valid, req_write;
  logic [3:0]  req_mode;
  logic [7:0]  opnd_lo, opnd_hi, reg_x, reg_y, reg_s, mem_rdata;
  logic [15:0] pc_next, mem_addr, ea;
  logic        busy, mem_rd, done, extra_cycle;
  int          errors, checks;
  logic [15:0] ov_a [4];
  logic [7:0]  ov_d [4];

  addr_gen_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_write(req_write), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .reg_x(reg_x),
    .reg_y(reg_y), .reg_s(reg_s), .pc_next(pc_next), .busy(busy), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .ea(ea),
    .extra_cycle(extra_cycle)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] r;
    r = a[7:0] ^ a[15:8] ^ 8'h5A;
    for (int i = 0; i < 4; i++) if (ov_a[i] == a) r = ov_d[i];
    return r;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mem(input logic [15:0] a0, input logic [7:0] d0,
                         input logic [15:0] a1, input logic [7:0] d1);
    ov_a[0] = a0; ov_d[0] = d0; ov_a[1] = a1; ov_d[1] = d1;
    ov_a[2] = 16'hFFFF; ov_d[2] = 8'h00; ov_a[3] = 16'hFFFF; ov_d[3] = 8'h00;
  endtask

  task automatic run(input logic [3:0] m, input logic w, input logic [7:0] lo, hi,
                     input logic [7:0] x, y, s, input logic [15:0] pc, input logic inj,
                     output logic [15:0] ea_o, output logic ex_o, output int lat,
                     output logic [15:0] rd0, rd1, output int nrd);
    @(negedge clk);
    req_mode = m; req_write = w; opnd_lo = lo; opnd_hi = hi;
    reg_x = x; reg_y = y; reg_s = s; pc_next = pc; req_valid = 1'b1;
    lat = 0; nrd = 0; rd0 = '0; rd1 = '0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1 && inj) begin
        req_mode = 4'd0; opnd_lo = 8'h99;
      end else begin
        req_valid = 1'b0;
      end
      if (mem_rd) begin
        if (nrd == 0) rd0 = mem_addr;
        else if (nrd == 1) rd1 = mem_addr;
        nrd++;
      end
    end while (!done && lat < 20);
    ea_o = ea; ex_o = extra_cycle;
    @(negedge clk);
    check("R11 done lasts one cycle", done, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 busy after reset", busy, 1'b0);
    check("R1 done after reset", done, 1'b0);
    check("R1 mem_rd after reset", mem_rd, 1'b0);
    check("R1 extra after reset", extra_cycle, 1'b0);
  endtask

  task automatic t_zero_page;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    run(4'd0, 0, 8'h44, 8'h77, 8'h00, 8'h00, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R2 zp ea", e, 16'h0044);
    check("R11 direct latency", l, 2);
    check("R13 zp no extra", xc, 1'b0);
    run(4'd1, 0, 8'hF0, 8'h77, 8'h20, 8'h00, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R2 zp+x wraps", e, 16'h0010);
    run(4'd2, 0, 8'h80, 8'h77, 8'h00, 8'h90, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R2 zp+y wraps", e, 16'h0010);
  endtask

  task automatic t_absolute;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    run(4'd3, 0, 8'h12, 8'h34, 8'h00, 8'h00, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R3 abs ea", e, 16'h3412);
    run(4'd13, 0, 8'hCD, 8'hAB, 8'h11, 8'h22, 8'h33, 16'h5555, 0, e, xc, l, a0, a1, n);
    check("R3 spare code as abs", e, 16'hABCD);
    check("R3 spare code latency", l, 2);
  endtask

  task automatic t_abs_indexed;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    run(4'd4, 0, 8'hF0, 8'h20, 8'h20, 8'h00, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R4 abs+x cross ea", e, 16'h2110);
    check("R4 cross read latency", l, 3);
    check("R13 cross read extra", xc, 1'b1);
    run(4'd4, 1, 8'hF0, 8'h20, 8'h20, 8'h00, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R4 cross write ea", e, 16'h2110);
    check("R4 cross write latency", l, 2);
    check("R13 cross write no extra", xc, 1'b0);
    run(4'd5, 0, 8'h10, 8'h20, 8'h00, 8'h05, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R4 abs+y same page", e, 16'h2015);
    check("R4 no cross latency", l, 2);
  endtask

  task automatic t_jump_indirect;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    set_mem(16'h30FF, 8'h78, 16'h3000, 8'h56);
    run(4'd6, 0, 8'hFF, 8'h30, 8'h00, 8'h00, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R5 page-wrap pointer ea", e, 16'h5678);
    check("R5 first read addr", a0, 16'h30FF);
    check("R5 second read same page", a1, 16'h3000);
    check("R10 two reads", n, 2);
    check("R11 pointer latency", l, 4);
  endtask

  task automatic t_pre_indexed;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    set_mem(16'h00FF, 8'h34, 16'h0000, 8'h12);
    run(4'd7, 0, 8'hF0, 8'h99, 8'h0F, 8'h00, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R6 ea", e, 16'h1234);
    check("R6 x added before read", a0, 16'h00FF);
    check("R6 high byte wraps in page 0", a1, 16'h0000);
  endtask

  task automatic t_post_indexed;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    set_mem(16'h0040, 8'hF0, 16'h0041, 8'h20);
    run(4'd8, 0, 8'h40, 8'h99, 8'h77, 8'h20, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R7 cross ea", e, 16'h2110);
    check("R7 reads at operand", a0, 16'h0040);
    check("R7 cross read latency", l, 5);
    check("R13 post-indexed extra", xc, 1'b1);
    run(4'd8, 0, 8'h40, 8'h99, 8'h77, 8'h05, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R7 same page ea", e, 16'h20F5);
    check("R7 same page latency", l, 4);
    run(4'd8, 1, 8'h40, 8'h99, 8'h77, 8'h20, 8'h00, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R7 write cross latency", l, 4);
    check("R13 write no extra", xc, 1'b0);
  endtask

  task automatic t_relative;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    run(4'd9, 0, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 0, e, xc, l, a0, a1, n);
    check("R8 back -128", e, 16'h0F80);
    run(4'd9, 0, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 0, e, xc, l, a0, a1, n);
    check("R8 forward +127", e, 16'h107F);
    run(4'd9, 0, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 16'h10F0, 0, e, xc, l, a0, a1, n);
    check("R8 page carry", e, 16'h1110);
  endtask

  task automatic t_stack;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    run(4'd10, 0, 8'h12, 8'h34, 8'h00, 8'h00, 8'hFD, 16'h0, 0, e, xc, l, a0, a1, n);
    check("R9 stack slot", e, 16'h01FD);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] e, a0, a1; logic xc; int l, n;
    set_mem(16'h0025, 8'hBC, 16'h0026, 8'h9A);
    run(4'd7, 0, 8'h20, 8'h00, 8'h05, 8'h00, 8'h00, 16'h0, 1, e, xc, l, a0, a1, n);
    check("R12 in-flight ea kept", e, 16'h9ABC);
    check("R12 in-flight latency kept", l, 4);
    repeat (3) @(negedge clk);
    check("R12 no second done", done, 1'b0);
    check("R12 idle after ignored req", busy, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_mode = '0;
    opnd_lo = '0; opnd_hi = '0; reg_x = '0; reg_y = '0; reg_s = '0; pc_next = '0;
    set_mem(16'hFFFF, 8'h00, 16'hFFFF, 8'h00);
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_zero_page();
    t_absolute();
    t_abs_indexed();
    t_jump_indirect();
    t_pre_indexed();
    t_post_indexed();
    t_relative();
    t_stack();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule